// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion after another. Each conversion runs through a sample phase and then a convert phase, both timed in cycles of a conversion clock. That clock does not toggle on its own. It is a one-cycle enable in the bus clock domain. A selector picks the enable source: either every bus clock or one of several external tick inputs. A divider then thins the selected ticks by 1, 2, 4 or 8.

A one-cycle `start` pulse begins a conversion. The first conversion after a start, and every single conversion, begins with a fixed number of bus cycles for synchronisation. A startup delay follows, counted in conversion clocks. After that comes the timed conversion itself. In continuous mode the next conversion follows straight on, without the synchronisation and startup overhead. The phase lengths are set by the resolution (8-bit, or 10/12-bit) and by the choice of short or long sample. The analog front end and the bit decisions are not part of this block. It only drives the strobes that time them.

Top module: `adc_conv_timer`

## Requirements
- R1: While reset is asserted, and after reset until a start arrives, `smp_en`, `cnv_en`, `done` and `busy` are all low.
- R2: `clk_src` selects the conversion tick source: 0 means every bus clock, and k = 1..3 means `ext_tick[k-1]`. `clk_div` values 0, 1, 2 and 3 let one conversion clock through per 1, 2, 4 or 8 selected ticks. The divider restarts from zero at each start.
- R3: A later conversion in a continuous run lasts exactly 17 conversion clocks (8-bit, short sample), 20 (10/12-bit, short), 37 (8-bit, long) or 40 (10/12-bit, long). The count runs from the done of the previous conversion to its own done.
- R4: A first or single conversion takes SYNC_BUS bus cycles after the edge that samples `start`. It then takes STARTUP conversion clocks, then the length given in R3, and then asserts `done`.
- R5: `smp_en` is high for the sample phase: SMP_SHORT conversion clocks, or SMP_SHORT+SMP_LONG_ADD with `long_smp` high. `cnv_en` is high for the rest of the conversion. The two strobes are never high together, and neither is high during synchronisation or startup.
- R6: `done` is high for exactly one bus cycle per conversion. When continuous mode is off, `busy` is already low in that cycle and the block stays idle.
- R7: With `cont_mode` high, the sample phase of the next conversion begins in the cycle `done` is high, without a new start. If `cont_mode` is low when a conversion ends, the run stops after that conversion.
- R8: A start during a conversion aborts it. The full first-conversion timing of R4 then begins again from the new start.
- R9: `busy` is high from the cycle after `start` is sampled until the conversion that ends the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion start request |
| cont_mode | input | 1 | Continuous conversion enable |
| long_smp | input | 1 | Long sample phase select |
| res_hi | input | 1 | 1: 10/12-bit timing, 0: 8-bit timing |
| clk_src | input | 2 | Conversion tick source select |
| clk_div | input | 2 | Conversion clock divide select (1, 2, 4, 8) |
| ext_tick | input | 3 | External tick enables |
| smp_en | output | 1 | Sample phase strobe |
| cnv_en | output | 1 | Convert phase strobe |
| done | output | 1 | One-cycle end-of-conversion pulse |
| busy | output | 1 | Conversion run in progress |

## Verification
The bench builds the block with its default parameters. These are 5 synchronisation cycles, an 8-clock startup delay, a 4-clock short sample with a 20-clock extension, and 13 or 16 convert clocks. With these values the four lengths of R3 are reached exactly, as directed checks on the bus source at divide-by-1. The external ticks run at periods 2, 3 and 5 against every divide ratio. This covers uneven tick spacing, the longest 8 × 5 pacing, aborts at random points and continuous runs of up to three conversions. Every run stays within the cycle limit.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SYNC    = 3'd1,
    PH_WARM    = 3'd2,
    PH_SAMPLE  = 3'd3,
    PH_CONVERT = 3'd4
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_tick_sel.sv
module adc_tick_sel #(
  parameter int N_EXT = 3,
  parameter int SRC_W = 2
) (
  input  logic [SRC_W-1:0] sel,
  input  logic [N_EXT-1:0] ext_tick,
  output logic             tick_o
);

  localparam int N_SLOT = 2 ** SRC_W;

  logic [N_SLOT-1:0] slot;

  // slot 0 is the bus clock itself, then the external ticks, unused slots idle
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    if (i == 0) begin : g_bus
      assign slot[i] = 1'b1;
    end else if (i <= N_EXT) begin : g_ext
      assign slot[i] = ext_tick[i-1];
    end else begin : g_off
      assign slot[i] = 1'b0;
    end
  end

  assign tick_o = slot[sel];

endmodule

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_sel,
  output logic             cck_o
);

  localparam int DCW = (2 ** DIV_W) - 1;

  logic [DCW-1:0] cnt_q, cnt_d, term;

  // terminal count is ratio-1 = a mask of div_sel ones
  always_comb begin
    term = '0;
    for (int i = 0; i < DCW; i++) begin
      if (i < int'(div_sel)) term[i] = 1'b1;
    end
  end

  assign cck_o = en && tick && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && tick) begin
      cnt_d = cck_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: with a ratio above one, two conversion clocks never fall in adjacent cycles
  assert_cck_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cck_o && (div_sel != '0)) |=> (!cck_o || !$stable(div_sel)));

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
  import adc_seq_pkg::*;
#(
  parameter int SYNC_BUS     = 5,
  parameter int STARTUP      = 8,
  parameter int SMP_SHORT    = 4,
  parameter int SMP_LONG_ADD = 20,
  parameter int CNV_LO       = 13,
  parameter int CNV_HI       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cont_mode,
  input  logic long_smp,
  input  logic res_hi,
  input  logic cck,
  output logic div_clr,
  output logic div_en,
  output logic smp_en,
  output logic cnv_en,
  output logic done,
  output logic busy
);

  localparam int MAXLEN = imax(imax(SYNC_BUS, STARTUP),
                               imax(SMP_SHORT + SMP_LONG_ADD, CNV_HI));
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] smp_last, cnv_last;

  assign smp_last = long_smp ? CNT_W'(SMP_SHORT + SMP_LONG_ADD - 1) : CNT_W'(SMP_SHORT - 1);
  assign cnv_last = res_hi   ? CNT_W'(CNV_HI - 1)                   : CNT_W'(CNV_LO - 1);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_SYNC: begin
          if (cnt_q == CNT_W'(SYNC_BUS - 1)) begin
            ph_d  = PH_WARM;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_WARM: begin
          if (cck) begin
            if (cnt_q == CNT_W'(STARTUP - 1)) begin
              ph_d  = PH_SAMPLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_SAMPLE: begin
          if (cck) begin
            if (cnt_q == smp_last) begin
              ph_d  = PH_CONVERT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_CONVERT: begin
          if (cck) begin
            if (cnt_q == cnv_last) begin
              done_d = 1'b1;
              ph_d   = cont_mode ? PH_SAMPLE : PH_IDLE;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign div_clr = start || (ph_q == PH_IDLE) || (ph_q == PH_SYNC);
  assign div_en  = (ph_q == PH_WARM) || (ph_q == PH_SAMPLE) || (ph_q == PH_CONVERT);
  assign smp_en  = (ph_q == PH_SAMPLE);
  assign cnv_en  = (ph_q == PH_CONVERT);
  assign done    = done_q;
  assign busy    = (ph_q != PH_IDLE);

  // R5: sample and convert strobes are exclusive
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_en && cnv_en));

  // R3: a done pulse only follows a convert phase
  assert_done_after_cnv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ph_q == PH_CONVERT));

  // R6: done lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a conversion ending without continuous mode leaves the block idle
  assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cont_mode)) |-> !busy);

  // R8: any start, even mid-conversion, restarts from synchronisation
  assert_restart_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph_q == PH_SYNC && cnt_q == '0));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int N_EXT        = 3,
  parameter int SRC_W        = 2,
  parameter int DIV_W        = 2,
  parameter int SYNC_BUS     = 5,
  parameter int STARTUP      = 8,
  parameter int SMP_SHORT    = 4,
  parameter int SMP_LONG_ADD = 20,
  parameter int CNV_LO       = 13,
  parameter int CNV_HI       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_mode,
  input  logic             long_smp,
  input  logic             res_hi,
  input  logic [SRC_W-1:0] clk_src,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [N_EXT-1:0] ext_tick,
  output logic             smp_en,
  output logic             cnv_en,
  output logic             done,
  output logic             busy
);

  logic src_tick;
  logic cck;
  logic div_clr;
  logic div_en;

  adc_tick_sel #(
    .N_EXT (N_EXT),
    .SRC_W (SRC_W)
  ) u_sel (
    .sel      (clk_src),
    .ext_tick (ext_tick),
    .tick_o   (src_tick)
  );

  adc_tick_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (div_clr),
    .en      (div_en),
    .tick    (src_tick),
    .div_sel (clk_div),
    .cck_o   (cck)
  );

  adc_phase_fsm #(
    .SYNC_BUS     (SYNC_BUS),
    .STARTUP      (STARTUP),
    .SMP_SHORT    (SMP_SHORT),
    .SMP_LONG_ADD (SMP_LONG_ADD),
    .CNV_LO       (CNV_LO),
    .CNV_HI       (CNV_HI)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cont_mode (cont_mode),
    .long_smp  (long_smp),
    .res_hi    (res_hi),
    .cck       (cck),
    .div_clr   (div_clr),
    .div_en    (div_en),
    .smp_en    (smp_en),
    .cnv_en    (cnv_en),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: tb/test_adc_conv_timer.sv
`timescale 1ns/1ps
module test_adc_conv_timer;

  localparam int SYNC_BUS     = 5;
  localparam int STARTUP      = 8;
  localparam int SMP_SHORT    = 4;
  localparam int SMP_LONG_ADD = 20;
  localparam int CNV_LO       = 13;
  localparam int CNV_HI       = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, cont_mode, long_smp, res_hi;
  logic [1:0] clk_src, clk_div;
  logic [2:0] ext_tick;
  logic       smp_en, cnv_en, done, busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  adc_conv_timer i_adc_conv_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
    .long_smp(long_smp), .res_hi(res_hi), .clk_src(clk_src), .clk_div(clk_div),
    .ext_tick(ext_tick), .smp_en(smp_en), .cnv_en(cnv_en), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int smp_len(input bit lng);
    return lng ? SMP_SHORT + SMP_LONG_ADD : SMP_SHORT;
  endfunction

  function automatic int conv_len(input bit lng, input bit hi);
    return smp_len(lng) + (hi ? CNV_HI : CNV_LO);
  endfunction

  function automatic bit tick_now();
    if (clk_src == 2'd0) return 1'b1;
    return ext_tick[clk_src - 2'd1];
  endfunction

  // external ticks with periods 2, 3 and 5 bus cycles
  initial begin
    int bcyc = 0;
    ext_tick = '0;
    forever begin
      @(negedge clk);
      bcyc++;
      ext_tick[0] = (bcyc % 2) == 0;
      ext_tick[1] = (bcyc % 3) == 0;
      ext_tick[2] = (bcyc % 5) == 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // follows one conversion from the current negedge; returns cycles until done
  task automatic run_conv(input bit first, input string req, output int kout);
    int k = 0, ticks = 0, c = 0, first_done = 0;
    int r  = 1 << clk_div;
    int st = first ? STARTUP : 0;
    int n  = st + conv_len(long_smp, res_hi);
    int sl = smp_len(long_smp);
    int bad_p = 0, bad_b = 0;
    bit exp_s, exp_c;
    forever begin
      @(posedge clk);
      k++;
      if ((!first || k > SYNC_BUS) && tick_now()) ticks++;
      @(negedge clk);
      c = ticks / r;
      if (done && first_done == 0) first_done = k;
      if (c == n || k > 40000) break;
      if (!busy) bad_b++;
      exp_s = (c >= st) && (c < st + sl);
      exp_c = (c >= st + sl);
      if (smp_en != exp_s || cnv_en != exp_c) bad_p++;
    end
    chk(done && first_done == k, req, first_done == 0 ? k + 1 : first_done, k);
    chk(bad_p == 0, "R5 strobe mismatches", bad_p, 0);
    chk(bad_b == 0, "R9 busy dropped early", bad_b, 0);
    kout = k;
  endtask

  task automatic idle_check(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done || busy || smp_en || cnv_en) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; cont_mode = 1'b0; long_smp = 1'b0; res_hi = 1'b0;
    clk_src = 2'd0; clk_div = 2'd0;
    repeat (3) @(negedge clk);
    chk(!smp_en && !cnv_en && !done && !busy, "R1 outputs in reset",
        {smp_en, cnv_en, done, busy}, 0);
    rst_n = 1'b1;
    idle_check(6, "R1 idle after reset");

    // single 8-bit short conversion on the bus clock, divide-by-1
    pulse_start();
    run_conv(1'b1, "R4 first conversion", k);
    chk(k == SYNC_BUS + STARTUP + 17, "R4 latency 8-bit short", k, SYNC_BUS + STARTUP + 17);
    chk(!busy, "R6 idle in done cycle", busy, 0);
    idle_check(30, "R6 stays idle");

    // continuous 10/12-bit short run of three, stop before the last ends
    res_hi = 1'b1; cont_mode = 1'b1;
    pulse_start();
    run_conv(1'b1, "R4 first of run", k);
    chk(busy && smp_en, "R7 next sample in done cycle", {busy, smp_en}, 3);
    run_conv(1'b0, "R3 later 10/12-bit short", k);
    chk(k == 20, "R3 length 20", k, 20);
    cont_mode = 1'b0;
    run_conv(1'b0, "R3 last of run", k);
    chk(k == 20, "R3 length 20 last", k, 20);
    chk(!busy, "R7 run stops", busy, 0);
    idle_check(40, "R7 no further conversion");

    // long sample, 8-bit, divide-by-2
    res_hi = 1'b0; long_smp = 1'b1; clk_div = 2'd1; cont_mode = 1'b1;
    pulse_start();
    run_conv(1'b1, "R4 first long", k);
    chk(k == SYNC_BUS + (STARTUP + 37) * 2, "R2 R4 divide-by-2 latency", k,
        SYNC_BUS + (STARTUP + 37) * 2);
    cont_mode = 1'b0;
    run_conv(1'b0, "R3 later 8-bit long", k);
    chk(k == 37 * 2, "R3 length 37", k, 74);

    // long sample, 10/12-bit, divide-by-8
    res_hi = 1'b1; clk_div = 2'd3; cont_mode = 1'b1;
    pulse_start();
    run_conv(1'b1, "R4 first long hi", k);
    cont_mode = 1'b0;
    run_conv(1'b0, "R3 later 10/12-bit long", k);
    chk(k == 40 * 8, "R3 length 40", k, 320);

    // abort mid-conversion
    res_hi = 1'b0; long_smp = 1'b0; clk_div = 2'd0;
    pulse_start();
    repeat (18) @(negedge clk);
    pulse_start();
    run_conv(1'b1, "R8 restart timing", k);
    chk(k == SYNC_BUS + STARTUP + 17, "R8 full first latency", k, SYNC_BUS + STARTUP + 17);

    // external tick source, period 3, divide-by-2
    clk_src = 2'd2; clk_div = 2'd1;
    pulse_start();
    run_conv(1'b1, "R2 external tick source", k);
    idle_check(5, "R6 idle after external run");

    // constrained random mix
    for (int t = 0; t < 25; t++) begin
      int nconv = 1 + ($urandom % 3);
      bit do_abort = ($urandom % 4) == 0;
      clk_src  = 2'($urandom % 4);
      clk_div  = 2'($urandom % 4);
      long_smp = 1'($urandom % 2);
      res_hi   = 1'($urandom % 2);
      cont_mode = (nconv > 1);
      pulse_start();
      if (do_abort) begin
        repeat (1 + ($urandom % 40)) @(negedge clk);
        pulse_start();
      end
      run_conv(1'b1, do_abort ? "R8 random abort" : "R4 random first", k);
      for (int j = 1; j < nconv; j++) begin
        chk(busy, "R7 continues", busy, 1);
        if (j == nconv - 1) cont_mode = 1'b0;
        run_conv(1'b0, "R3 random later", k);
      end
      chk(!busy, "R6 R7 idle at end", busy, 0);
      idle_check(3 + ($urandom % 10), "R6 random idle");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule